// File: doc/BRIEF.md
# I2C Bus Timing and Start/Stop Condition Generator

This block is the bus-condition engine of an I2C master. From two programmable divider fields it derives the length of the SCL low phase and the SCL high phase. It uses them to place START, repeated START and STOP conditions on the bus. It drives open-drain enables: a 1 on `scl_oe` or `sda_oe` pulls that line low, and a 0 releases it so the pull-up takes it high. A byte engine or software sets a one-shot command. The block latches it, runs the sequence, and drops the command bit once the condition is on the bus. At the same moment it sets a done flag in a write-one-to-clear pending register, and that register feeds a maskable interrupt.

Each SCL low phase lasts 8·(low field + 1) system clocks, and each high phase lasts 8·(high field + 1). One full SCL period is therefore 8·((low+1)+(high+1)) clocks. To reach a target rate f from a clock fclk, software computes d = ceil(fclk/(8·f)) − 2 and loads low = floor(d/2) and high = ceil(d/2). When d is negative, it loads zero into both fields. Clearing the enable releases both lines at once and abandons any condition in flight.

Top module: `i2c_cond_gen`

## Requirements
- R1: After reset both line enables are 0 (lines released), both command-busy outputs are 0, the pending register is 0 and `irq` is 0.
- R2: Every SCL low phase the block produces lasts 8·(`div_lo`+1) clocks and every high phase lasts 8·(`div_hi`+1) clocks, so one SCL period is 8·((`div_lo`+1)+(`div_hi`+1)) clocks.
- R3: A START on a free bus, with the command latched at edge N, keeps both lines released until edge N+1+H (H = high phase length). It then pulls SDA low with SCL released, and it pulls SCL low at edge N+1+2H. The bus stays held with both lines low afterwards.
- R4: A START issued while the bus is held first releases SDA with SCL low for one low phase (L clocks, from edge N+1). It then releases SCL for one high phase and continues as in R3, so SCL is pulled low again at edge N+1+L+2H.
- R5: A STOP issued while the bus is held keeps both lines low for one low phase from edge N+1. It then releases SCL with SDA low for one high phase, and it releases SDA at edge N+1+L+H, leaving the bus free.
- R6: A STOP on an already free bus changes no line and completes at edge N+1.
- R7: Pending bit 0 (START done) is set at the edge where SCL is pulled low to end a START. Pending bit 1 (STOP done) is set at the edge where SDA is released to end a STOP, or at the completion edge of R6.
- R8: While `pnd_clr_we` is 1, each pending bit whose `pnd_clr` bit is 1 clears at that edge and the other bits keep their value. Writing 2'b11 clears both bits. A bit being set in the same cycle stays set.
- R9: `irq` is 1 exactly when some pending bit and its `irq_en` bit are both 1.
- R10: A command sets its busy output from the edge that samples it until the edge where its condition completes, then the busy output clears by itself. Commands sampled while `en` is 0 are ignored.
- R11: With `en` at 0, both lines are released at the next edge, latched commands are dropped, and the abandoned condition sets no pending bit.
- R12: When START and STOP are both pending on a free bus, the START is generated first and the STOP follows at the edge after the START completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Controller enable; 0 forces idle and releases the bus |
| div_lo | input | DIV_W | SCL low-phase divider field |
| div_hi | input | DIV_W | SCL high-phase divider field |
| start_cmd | input | 1 | One-cycle request for a START (or repeated START) |
| stop_cmd | input | 1 | One-cycle request for a STOP |
| irq_en | input | 2 | Interrupt enables; bit 0 START done, bit 1 STOP done |
| pnd_clr_we | input | 1 | Write strobe for the pending clear |
| pnd_clr | input | 2 | Write-one-to-clear mask for the pending bits |
| scl_oe | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| start_busy | output | 1 | START command latched and not yet completed |
| stop_busy | output | 1 | STOP command latched and not yet completed |
| pending | output | 2 | Pending flags; bit 0 START done, bit 1 STOP done |
| irq | output | 1 | Interrupt request |

## Verification
The embedded properties watch several things on every cycle. SDA may only be pulled low while SCL is released, both now and in the previous cycle. A cleared enable must release both lines on the following edge. Write-one-to-clear must remove exactly the masked bits unless a set coincides, and a finished START must show up as a pending flag with the bus held. A STOP on a free bus must finish at once. Other properties concern exact timing and ordering, and only the bench scenarios can show them. These include the phase lengths for several divider settings, the edge at which each line changes in START, repeated START and STOP, the START-before-STOP ordering, interrupt masking, and the silence after commands given while disabled.

// File: rtl/i2cbc_pkg.sv
package i2cbc_pkg;

    typedef enum logic [2:0] {
        ST_FREE    = 3'd0,  // both lines released, bus idle
        ST_HELD    = 3'd1,  // both lines low, bus owned
        ST_RS_LOW  = 3'd2,  // SCL low, SDA released before a repeated START
        ST_SETUP   = 3'd3,  // both released, START setup
        ST_HOLD    = 3'd4,  // SDA low, SCL released, START hold
        ST_P_LOW   = 3'd5,  // both low before STOP
        ST_P_HIGH  = 3'd6   // SCL released, SDA low, STOP setup
    } bus_st_e;

    localparam int unsigned EVT_NUM   = 2;
    localparam int unsigned EVT_START = 0;
    localparam int unsigned EVT_STOP  = 1;

endpackage

// File: rtl/i2cbc_phase_timer.sv
module i2cbc_phase_timer #(
    parameter int unsigned DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             load,
    input  logic             sel_high,
    input  logic [DIV_W-1:0] div_lo,
    input  logic [DIV_W-1:0] div_hi,
    output logic             expired
);
    // A phase of 8*(div+1) clocks loads a count of 8*div+7.
    localparam int unsigned CW = DIV_W + 3;

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (!en) begin
            tmr_d.cnt = '0;
        end else if (load) begin
            tmr_d.cnt = {(sel_high ? div_hi : div_lo), 3'b111};
        end else if (tmr_q.cnt != '0) begin
            tmr_d.cnt = tmr_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign expired = (tmr_q.cnt == '0);

endmodule

// File: rtl/i2cbc_pend_irq.sv
module i2cbc_pend_irq #(
    parameter int unsigned N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic         clr_we,
    input  logic [N-1:0] clr,
    input  logic [N-1:0] ien,
    output logic [N-1:0] pnd,
    output logic         irq
);
    typedef struct packed {
        logic [N-1:0] pnd;
    } pir_t;

    pir_t pir_d, pir_q;
    logic [N-1:0] clr_eff;

    always_comb begin
        pir_d   = pir_q;
        clr_eff = clr_we ? clr : '0;
        for (int i = 0; i < N; i++) begin
            if (set[i]) begin
                pir_d.pnd[i] = 1'b1;
            end else if (clr_eff[i]) begin
                pir_d.pnd[i] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pir_q <= '0;
        end else begin
            pir_q <= pir_d;
        end
    end

    assign pnd = pir_q.pnd;
    assign irq = |(pir_q.pnd & ien);

    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        clr_we |=> ((pnd & $past(clr & ~set)) == '0)); // R8
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (|set) |=> ((pnd & $past(set)) == $past(set))); // R8

endmodule

// File: rtl/i2cbc_seq.sv
module i2cbc_seq
    import i2cbc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic start_cmd,
    input  logic stop_cmd,
    input  logic tmr_expired,
    output logic tmr_load,
    output logic tmr_sel_high,
    output logic start_done,
    output logic stop_done,
    output logic start_busy,
    output logic stop_busy,
    output logic scl_oe,
    output logic sda_oe
);
    typedef struct packed {
        bus_st_e st;
        logic    want_start;
        logic    want_stop;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d        = seq_q;
        tmr_load     = 1'b0;
        tmr_sel_high = 1'b0;
        start_done   = 1'b0;
        stop_done    = 1'b0;
        if (!en) begin
            seq_d.st         = ST_FREE;
            seq_d.want_start = 1'b0;
            seq_d.want_stop  = 1'b0;
        end else begin
            unique case (seq_q.st)
                ST_FREE: begin
                    if (seq_q.want_start) begin
                        seq_d.st     = ST_SETUP;
                        tmr_load     = 1'b1;
                        tmr_sel_high = 1'b1;
                    end else if (seq_q.want_stop) begin
                        stop_done       = 1'b1;
                        seq_d.want_stop = 1'b0;
                    end
                end
                ST_HELD: begin
                    if (seq_q.want_start) begin
                        seq_d.st = ST_RS_LOW;
                        tmr_load = 1'b1;
                    end else if (seq_q.want_stop) begin
                        seq_d.st = ST_P_LOW;
                        tmr_load = 1'b1;
                    end
                end
                ST_RS_LOW: begin
                    if (tmr_expired) begin
                        seq_d.st     = ST_SETUP;
                        tmr_load     = 1'b1;
                        tmr_sel_high = 1'b1;
                    end
                end
                ST_SETUP: begin
                    if (tmr_expired) begin
                        seq_d.st     = ST_HOLD;
                        tmr_load     = 1'b1;
                        tmr_sel_high = 1'b1;
                    end
                end
                ST_HOLD: begin
                    if (tmr_expired) begin
                        seq_d.st         = ST_HELD;
                        start_done       = 1'b1;
                        seq_d.want_start = 1'b0;
                    end
                end
                ST_P_LOW: begin
                    if (tmr_expired) begin
                        seq_d.st     = ST_P_HIGH;
                        tmr_load     = 1'b1;
                        tmr_sel_high = 1'b1;
                    end
                end
                ST_P_HIGH: begin
                    if (tmr_expired) begin
                        seq_d.st        = ST_FREE;
                        stop_done       = 1'b1;
                        seq_d.want_stop = 1'b0;
                    end
                end
                default: begin
                    seq_d.st = ST_FREE;
                end
            endcase
            if (start_cmd) seq_d.want_start = 1'b1;
            if (stop_cmd)  seq_d.want_stop  = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{st: ST_FREE, want_start: 1'b0, want_stop: 1'b0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign scl_oe     = (seq_q.st == ST_HELD) || (seq_q.st == ST_RS_LOW) ||
                        (seq_q.st == ST_P_LOW);
    assign sda_oe     = (seq_q.st == ST_HELD) || (seq_q.st == ST_HOLD) ||
                        (seq_q.st == ST_P_LOW) || (seq_q.st == ST_P_HIGH);
    assign start_busy = seq_q.want_start;
    assign stop_busy  = seq_q.want_stop;

    AST_SDA_FALLS_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> (!scl_oe && $past(!scl_oe))); // R3
    AST_DISABLE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!scl_oe && !sda_oe && !start_busy && !stop_busy)); // R11
    AST_STOP_ON_FREE_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !scl_oe && !sda_oe && stop_busy && !start_busy && (seq_q.st == ST_FREE))
        |=> (!stop_busy && !scl_oe && !sda_oe)); // R6

endmodule

// File: rtl/i2c_cond_gen.sv
module i2c_cond_gen
    import i2cbc_pkg::*;
#(
    parameter int unsigned DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] div_lo,
    input  logic [DIV_W-1:0] div_hi,
    input  logic             start_cmd,
    input  logic             stop_cmd,
    input  logic [1:0]       irq_en,
    input  logic             pnd_clr_we,
    input  logic [1:0]       pnd_clr,
    output logic             scl_oe,
    output logic             sda_oe,
    output logic             start_busy,
    output logic             stop_busy,
    output logic [1:0]       pending,
    output logic             irq
);
    logic tmr_load, tmr_sel_high, tmr_expired;
    logic start_done, stop_done;
    logic [EVT_NUM-1:0] evt_set;

    i2cbc_phase_timer #(.DIV_W(DIV_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .load     (tmr_load),
        .sel_high (tmr_sel_high),
        .div_lo   (div_lo),
        .div_hi   (div_hi),
        .expired  (tmr_expired)
    );

    i2cbc_seq u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .en           (en),
        .start_cmd    (start_cmd),
        .stop_cmd     (stop_cmd),
        .tmr_expired  (tmr_expired),
        .tmr_load     (tmr_load),
        .tmr_sel_high (tmr_sel_high),
        .start_done   (start_done),
        .stop_done    (stop_done),
        .start_busy   (start_busy),
        .stop_busy    (stop_busy),
        .scl_oe       (scl_oe),
        .sda_oe       (sda_oe)
    );

    always_comb begin
        evt_set            = '0;
        evt_set[EVT_START] = start_done;
        evt_set[EVT_STOP]  = stop_done;
    end

    i2cbc_pend_irq #(.N(EVT_NUM)) u_pend (
        .clk    (clk),
        .rst_n  (rst_n),
        .set    (evt_set),
        .clr_we (pnd_clr_we),
        .clr    (pnd_clr),
        .ien    (irq_en),
        .pnd    (pending),
        .irq    (irq)
    );

    AST_START_DONE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        start_done |=> (pending[EVT_START] && scl_oe && sda_oe && !start_busy)); // R7
    AST_STOP_DONE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        stop_done |=> (pending[EVT_STOP] && !scl_oe && !sda_oe)); // R7

endmodule

// File: tb/tb_i2c_cond_gen.sv
module tb_i2c_cond_gen;
    localparam int unsigned DIV_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             en = 1'b0;
    logic [DIV_W-1:0] div_lo = '0;
    logic [DIV_W-1:0] div_hi = '0;
    logic             start_cmd = 1'b0;
    logic             stop_cmd = 1'b0;
    logic [1:0]       irq_en = '0;
    logic             pnd_clr_we = 1'b0;
    logic [1:0]       pnd_clr = '0;
    logic             scl_oe, sda_oe, start_busy, stop_busy, irq;
    logic [1:0]       pending;

    i2c_cond_gen #(.DIV_W(DIV_W)) dut (
        .clk(clk), .rst_n(rst_n), .en(en), .div_lo(div_lo), .div_hi(div_hi),
        .start_cmd(start_cmd), .stop_cmd(stop_cmd), .irq_en(irq_en),
        .pnd_clr_we(pnd_clr_we), .pnd_clr(pnd_clr), .scl_oe(scl_oe),
        .sda_oe(sda_oe), .start_busy(start_busy), .stop_busy(stop_busy),
        .pending(pending), .irq(irq)
    );

    always #2.5 clk = ~clk;

    typedef struct {
        logic [1:0]  lines;   // {scl_oe, sda_oe}
        int unsigned at;
        string       req;
    } exp_t;

    exp_t        q_exp[$];
    exp_t        got;
    int unsigned cyc = 0;
    int          n_cmp = 0;
    int          n_bad = 0;
    logic [1:0]  prev_lines = 2'b00;
    logic [1:0]  cur_lines;
    bit          finished = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(string req, int act, int exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // monitor: every line change must match the head of the expected queue
    always @(negedge clk) begin
        if (rst_n) begin
            cur_lines = {scl_oe, sda_oe};
            if (cur_lines !== prev_lines) begin
                if (q_exp.size() == 0) begin
                    n_cmp++;
                    n_bad++;
                    $display("FAIL R3 unexpected line change actual=%0d expected=%0d",
                             cur_lines, prev_lines);
                end else begin
                    got = q_exp.pop_front();
                    chk({got.req, " lines"}, int'(cur_lines), int'(got.lines));
                    chk({got.req, " edge"}, int'(cyc), int'(got.at));
                end
            end
            prev_lines = cur_lines;
        end
    end

    function automatic int ph(int div);
        return 8 * (div + 1);
    endfunction

    task automatic push(logic [1:0] lines, int unsigned at, string req);
        exp_t e;
        e.lines = lines; e.at = at; e.req = req;
        q_exp.push_back(e);
    endtask

    task automatic wait_cyc(int unsigned c);
        while (cyc < c) @(negedge clk);
    endtask

    task automatic pulse(bit s, bit p, output int unsigned n);
        @(negedge clk);
        n = cyc + 1;
        start_cmd = s;
        stop_cmd  = p;
        @(negedge clk);
        start_cmd = 1'b0;
        stop_cmd  = 1'b0;
    endtask

    task automatic clear_pnd(logic [1:0] m);
        @(negedge clk);
        pnd_clr_we = 1'b1;
        pnd_clr    = m;
        @(negedge clk);
        pnd_clr_we = 1'b0;
        pnd_clr    = '0;
    endtask

    task automatic set_div(int dl, int dh);
        @(negedge clk);
        div_lo = DIV_W'(dl);
        div_hi = DIV_W'(dh);
    endtask

    // rate -> divider fields, per the loading rule for software
    task automatic rate_fields(int fclk, int fscl, output int dl, output int dh);
        int d;
        d = (fclk + 8 * fscl - 1) / (8 * fscl) - 2;
        if (d < 0) begin dl = 0; dh = 0; end
        else begin dl = d / 2; dh = d - d / 2; end
    endtask

    initial begin
        int unsigned n;
        int dl, dh, L, H;

        repeat (4) @(negedge clk);
        // R1 reset state
        chk("R1 scl_oe", scl_oe, 0);
        chk("R1 sda_oe", sda_oe, 0);
        chk("R1 pending", pending, 0);
        chk("R1 irq", irq, 0);
        chk("R1 busy", {start_busy, stop_busy}, 0);
        rst_n = 1'b1;

        @(negedge clk);
        en = 1'b1;
        irq_en = 2'b11;
        set_div(0, 0);
        L = ph(0); H = ph(0);

        // R3 START on free bus, R7 done flag, R10 busy
        pulse(1, 0, n);
        push(2'b01, n + 1 + H, "R3 sda low");
        push(2'b11, n + 1 + 2 * H, "R3 scl low");
        chk("R10 start_busy while running", start_busy, 1);
        wait_cyc(n + 2 * H);
        chk("R7 no start flag before completion", pending[0], 0);
        wait_cyc(n + 1 + 2 * H);
        chk("R7 start flag", pending, 2'b01);
        chk("R10 start_busy self-clear", start_busy, 0);
        chk("R9 irq on start flag", irq, 1);

        // R8 clear one bit
        clear_pnd(2'b01);
        chk("R8 single clear", pending, 2'b00);
        chk("R9 irq low after clear", irq, 0);

        // R5 STOP from held bus
        pulse(0, 1, n);
        push(2'b01, n + 1 + L, "R5 scl released");
        push(2'b00, n + 1 + L + H, "R5 sda released");
        wait_cyc(n + 1 + L + H);
        chk("R7 stop flag", pending, 2'b10);
        chk("R10 stop_busy self-clear", stop_busy, 0);

        // R9 masking
        @(negedge clk);
        irq_en = 2'b01;
        @(negedge clk);
        chk("R9 masked stop flag", irq, 0);
        irq_en = 2'b10;
        @(negedge clk);
        chk("R9 unmasked stop flag", irq, 1);
        irq_en = 2'b11;

        // R6 STOP on free bus; clear only bit 0 first to prove R8 keeps bit 1
        clear_pnd(2'b01);
        chk("R8 unmasked bit kept", pending, 2'b10);
        clear_pnd(2'b11);
        chk("R8 clear all", pending, 2'b00);
        pulse(0, 1, n);
        wait_cyc(n);
        wait_cyc(n + 1);
        chk("R6 stop on free bus done", pending, 2'b10);
        chk("R6 stop_busy cleared", stop_busy, 0);
        clear_pnd(2'b11);

        // R2 R4 divider from a 1 MHz target at 200 MHz, repeated START
        rate_fields(200, 1, dl, dh);
        chk("R2 low field", dl, 11);
        chk("R2 high field", dh, 12);
        set_div(dl, dh);
        L = ph(dl); H = ph(dh);
        chk("R2 period", L + H, 200);
        pulse(1, 0, n);
        push(2'b01, n + 1 + H, "R2 start hold");
        push(2'b11, n + 1 + 2 * H, "R2 start scl low");
        wait_cyc(n + 1 + 2 * H);
        clear_pnd(2'b11);
        pulse(1, 0, n);
        push(2'b10, n + 1, "R4 sda released");
        push(2'b00, n + 1 + L, "R4 low phase length");
        push(2'b01, n + 1 + L + H, "R4 high phase length");
        push(2'b11, n + 1 + L + 2 * H, "R4 scl low again");
        wait_cyc(n + 1 + L + 2 * H);
        chk("R4 start flag", pending, 2'b01);
        pulse(0, 1, n);
        push(2'b01, n + 1 + L, "R5 low phase");
        push(2'b00, n + 1 + L + H, "R5 high phase");
        wait_cyc(n + 1 + L + H);
        chk("R5 flags", pending, 2'b11);
        clear_pnd(2'b11);

        // R12 both commands together on a free bus
        set_div(1, 2);
        L = ph(1); H = ph(2);
        pulse(1, 1, n);
        push(2'b01, n + 1 + H, "R12 start first");
        push(2'b11, n + 1 + 2 * H, "R12 start done");
        push(2'b01, n + 2 + 2 * H + L, "R12 stop follows");
        push(2'b00, n + 2 + 2 * H + L + H, "R12 stop done");
        wait_cyc(n + 1 + 2 * H);
        chk("R12 only start flag", pending, 2'b01);
        chk("R12 stop still busy", stop_busy, 1);
        wait_cyc(n + 2 + 3 * H + L);
        chk("R12 both flags", pending, 2'b11);
        clear_pnd(2'b11);

        // R11 disable during the START hold phase
        set_div(0, 0);
        H = ph(0);
        pulse(1, 0, n);
        push(2'b01, n + 1 + H, "R11 hold entered");
        wait_cyc(n + 3 + H);
        push(2'b00, cyc + 1, "R11 release on disable");
        en = 1'b0;
        repeat (40) @(negedge clk);
        chk("R11 no flag", pending, 2'b00);
        chk("R11 command dropped", start_busy, 0);

        // R10 commands ignored while disabled
        pulse(1, 1, n);
        repeat (30) @(negedge clk);
        chk("R10 ignored start", start_busy, 0);
        chk("R10 ignored stop", stop_busy, 0);
        chk("R10 no flags", pending, 2'b00);
        en = 1'b1;
        repeat (30) @(negedge clk);
        chk("R10 nothing replayed", {scl_oe, sda_oe}, 0);

        chk("R3 all expected line changes seen", q_exp.size(), 0);
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_cmp++;
            n_bad++;
            $display("FAIL R1 watchdog actual=%0d expected=%0d", cyc, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule